// File: doc/BRIEF.md
# Lock-Qualified Cascaded Reset Sequencer

This block produces the reset for functional logic whose clock comes from a chain of on-chip clock synthesizers. Each synthesizer raises a lock flag once its output clock is stable. The board power-on reset drives the reset of the first synthesizer directly. Each later synthesizer is held in reset until every synthesizer before it in the chain reports lock.

The functional logic gets an active-low reset. It is asserted at once, with no clock needed, whenever power-on reset is active or any lock flag is low. This covers the time when the final clock may still have irregular periods. It is released only on an edge of the final clock. Release comes after the combined lock has passed through a two-flop synchronizer and then stayed high for a further 16 clock cycles. Because the release is synchronous, every downstream flip-flop leaves reset on the same edge, so one-hot state machines stay one-hot.

A status output mirrors the released state for monitors.

Top module: `lock_reset_sequencer`

## Requirements
- R1: `synth_rst_o[0]` equals `por_i` at all times, with no clock edge needed.
- R2: For stage k ≥ 1, `synth_rst_o[k]` is high (reset) whenever `por_i` is high or any of `lock_i[k-1:0]` is low. It is low otherwise. A lock flag of a later stage has no effect on earlier stage resets.
- R3: While `por_i` is high, every `synth_rst_o` bit is 1 and `func_rst_n_o` and `ready_o` are 0, whatever the lock inputs are.
- R4: When any lock flag is low, `func_rst_n_o` is 0 in the same time step, without waiting for a clock edge.
- R5: Count the rising edges of `clk_i` from the first edge at which `por_i` is low and all locks are high, counting that edge as 1. `func_rst_n_o` rises exactly at edge SYNC_STAGES + HOLD_CYCLES, which is edge 18 with the defaults. Any loss of lock, or any `por_i` pulse, restarts the count.
- R6: Once released, `func_rst_n_o` stays high for as long as `por_i` stays low and all locks stay high.
- R7: `ready_o` equals `func_rst_n_o` at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Output clock of the last synthesizer |
| por_i | input | 1 | Board power-on reset, active high, asynchronous |
| lock_i | input | NUM_STAGES | Lock flags, bit k from synthesizer stage k |
| synth_rst_o | output | NUM_STAGES | Active-high reset to each synthesizer stage |
| func_rst_n_o | output | 1 | Active-low reset for functional logic |
| ready_o | output | 1 | High once the functional reset is released |

## Verification
The locks are first raised stage by stage. This separates cumulative chaining from per-stage gating, since a later lock raised alone must not release its successor. A full lock is then held long enough to find the exact release edge. This shows whether the synchronizer depth or the hold count is off by one. Dropouts before and after release show that assertion does not wait for the clock and that the count restarts. A short power-on pulse while locked shows that power-on reset overrides the lock inputs.

// File: rtl/lrs_pkg.sv
package lrs_pkg;
   localparam int unsigned LRS_MAX_STAGES = 3;
   localparam int unsigned LRS_MIN_SYNC   = 2;

   function automatic int unsigned lrs_cnt_width(input int unsigned limit);
      return (limit < 2) ? 1 : $clog2(limit);
   endfunction
endpackage

// File: rtl/lrs_stage_chain.sv
module lrs_stage_chain #(
   parameter int unsigned NUM_STAGES = 3
) (
   input  logic                  por_i,
   input  logic [NUM_STAGES-1:0] lock_i,
   output logic [NUM_STAGES-1:0] synth_rst_o,
   output logic                  chain_ok_o
);
   logic [NUM_STAGES:0] ok_prefix;

   assign ok_prefix[0] = 1'b1;

   for (genvar k = 0; k < NUM_STAGES; k++) begin : g_stage
      assign ok_prefix[k+1]  = ok_prefix[k] & lock_i[k];
      assign synth_rst_o[k]  = por_i | ~ok_prefix[k];
   end

   assign chain_ok_o = ok_prefix[NUM_STAGES];
endmodule

// File: rtl/lrs_sync.sv
module lrs_sync #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk_i,
   input  logic arst_i,
   output logic q_o
);
   logic [SYNC_STAGES-1:0] shift_q;

   always_ff @(posedge clk_i or posedge arst_i) begin
      if (arst_i) shift_q <= '0;
      else        shift_q <= {shift_q[SYNC_STAGES-2:0], 1'b1};
   end

   assign q_o = shift_q[SYNC_STAGES-1];
endmodule

// File: rtl/lrs_hold_counter.sv
module lrs_hold_counter
   import lrs_pkg::*;
#(
   parameter int unsigned HOLD_CYCLES = 16
) (
   input  logic clk_i,
   input  logic arst_i,
   input  logic start_i,
   output logic done_o
);
   localparam int unsigned CW = lrs_cnt_width(HOLD_CYCLES);
   localparam logic [CW-1:0] LAST = CW'(HOLD_CYCLES - 1);

   logic [CW-1:0] cnt_q;
   logic          done_q;

   always_ff @(posedge clk_i or posedge arst_i) begin
      if (arst_i) begin
         cnt_q  <= '0;
         done_q <= 1'b0;
      end else if (start_i && !done_q) begin
         if (cnt_q == LAST) done_q <= 1'b1;
         else               cnt_q  <= cnt_q + 1'b1;
      end
   end

   assign done_o = done_q;
endmodule

// File: rtl/lock_reset_sequencer.sv
module lock_reset_sequencer
   import lrs_pkg::*;
#(
   parameter int unsigned NUM_STAGES  = 3,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned HOLD_CYCLES = 16
) (
   input  logic                  clk_i,
   input  logic                  por_i,
   input  logic [NUM_STAGES-1:0] lock_i,
   output logic [NUM_STAGES-1:0] synth_rst_o,
   output logic                  func_rst_n_o,
   output logic                  ready_o
);
   if (NUM_STAGES < 1 || NUM_STAGES > LRS_MAX_STAGES) begin : g_bad_stages
      $error("NUM_STAGES out of range");
   end
   if (SYNC_STAGES < LRS_MIN_SYNC) begin : g_bad_sync
      $error("SYNC_STAGES too small");
   end
   if (HOLD_CYCLES < 2) begin : g_bad_hold
      $error("HOLD_CYCLES too small");
   end

   logic chain_ok;
   logic domain_arst;
   logic lock_synced;
   logic released;

   lrs_stage_chain #(.NUM_STAGES(NUM_STAGES)) u_chain (
      .por_i       (por_i),
      .lock_i      (lock_i),
      .synth_rst_o (synth_rst_o),
      .chain_ok_o  (chain_ok)
   );

   assign domain_arst = por_i | ~chain_ok;

   lrs_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk_i  (clk_i),
      .arst_i (domain_arst),
      .q_o    (lock_synced)
   );

   lrs_hold_counter #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
      .clk_i   (clk_i),
      .arst_i  (domain_arst),
      .start_i (lock_synced),
      .done_o  (released)
   );

   assign func_rst_n_o = released;
   assign ready_o      = released;
endmodule

// File: rtl/lrs_checker.sv
module lrs_checker #(
   parameter int unsigned NUM_STAGES  = 3,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned HOLD_CYCLES = 16
) (
   input logic                  clk_i,
   input logic                  por_i,
   input logic [NUM_STAGES-1:0] lock_i,
   input logic [NUM_STAGES-1:0] synth_rst_o,
   input logic                  func_rst_n_o,
   input logic                  ready_o
);
   localparam int unsigned RELEASE_EDGE = SYNC_STAGES + HOLD_CYCLES;

   int unsigned lock_run;

   always_ff @(posedge clk_i or posedge por_i) begin
      if (por_i)                lock_run <= 0;
      else if (!(&lock_i))      lock_run <= 0;
      else if (lock_run < 4095) lock_run <= lock_run + 1;
   end

   for (genvar k = 1; k < NUM_STAGES; k++) begin : g_chain_chk
      AST_CHAIN_HOLD: assert property (@(posedge clk_i) disable iff (por_i)
         !lock_i[k-1] |-> synth_rst_o[k]); // R2
   end

   AST_UNLOCK_ASSERTS: assert property (@(posedge clk_i) disable iff (por_i)
      !(&lock_i) |-> !func_rst_n_o); // R4

   AST_RELEASE_EDGE: assert property (@(posedge clk_i) disable iff (por_i)
      $rose(func_rst_n_o) |-> (lock_run == RELEASE_EDGE)); // R5

   AST_STAYS_RELEASED: assert property (@(posedge clk_i) disable iff (por_i)
      (func_rst_n_o && (&lock_i)) |=> (func_rst_n_o || !(&lock_i))); // R6

   AST_READY_TRACKS: assert property (@(posedge clk_i) disable iff (por_i)
      ready_o == func_rst_n_o); // R7
endmodule

bind lock_reset_sequencer lrs_checker #(
   .NUM_STAGES  (NUM_STAGES),
   .SYNC_STAGES (SYNC_STAGES),
   .HOLD_CYCLES (HOLD_CYCLES)
) u_lrs_checker (
   .clk_i        (clk_i),
   .por_i        (por_i),
   .lock_i       (lock_i),
   .synth_rst_o  (synth_rst_o),
   .func_rst_n_o (func_rst_n_o),
   .ready_o      (ready_o)
);

// File: tb/test_lock_reset_sequencer.sv
module test_lock_reset_sequencer;
   localparam int NS   = 3;
   localparam int REL  = 2 + 16;

   logic          clk = 1'b0;
   logic          por_r = 1'b1;
   logic [NS-1:0] lock_r = '0;
   logic [NS-1:0] synth_rst;
   logic          func_rst_n;
   logic          ready;

   int checks = 0;
   int errors = 0;
   int mcnt   = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   lock_reset_sequencer #(.NUM_STAGES(NS), .SYNC_STAGES(2), .HOLD_CYCLES(16)) i_lock_reset_sequencer (
      .clk_i        (clk),
      .por_i        (por_r),
      .lock_i       (lock_r),
      .synth_rst_o  (synth_rst),
      .func_rst_n_o (func_rst_n),
      .ready_o      (ready)
   );

   // reference model: edges with all locks high and no power-on reset
   always @(posedge clk) begin
      if (por_r || !(&lock_r)) mcnt <= 0;
      else if (mcnt < 1000)    mcnt <= mcnt + 1;
   end

   task automatic check(input string tag, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %b expected %b at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic compare();
      logic       all_ok;
      logic       exp_rel;
      string      tag;
      all_ok  = &lock_r;
      exp_rel = !por_r && all_ok && (mcnt >= REL);
      for (int k = 0; k < NS; k++) begin
         logic prefix;
         prefix = 1'b1;
         for (int j = 0; j < k; j++) prefix = prefix & lock_r[j];
         if (k == 0) check("R1", synth_rst[0], por_r);
         else        check("R2", synth_rst[k], por_r | ~prefix);
      end
      if (por_r)          tag = "R3";
      else if (!all_ok)   tag = "R4";
      else if (mcnt > REL) tag = "R6";
      else                tag = "R5";
      check(tag, func_rst_n, exp_rel);
      check("R7", ready, func_rst_n);
      if (por_r) check("R3", ready, 1'b0);
   endtask

   task automatic step(input logic p, input logic [NS-1:0] lk, input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         por_r  = p;
         lock_r = lk;
         #1 compare();
      end
   endtask

   initial begin
      step(1'b1, 3'b000, 5);   // R3 power-on
      step(1'b1, 3'b111, 3);   // R3 locks ignored under power-on
      step(1'b0, 3'b000, 4);
      step(1'b0, 3'b001, 5);   // R2 stage 1 freed only
      step(1'b0, 3'b101, 3);   // R2 later lock alone frees nothing
      step(1'b0, 3'b011, 5);
      step(1'b0, 3'b111, 25);  // R5 release on edge 18, R6 hold
      step(1'b0, 3'b101, 2);   // R4 immediate assertion
      step(1'b0, 3'b111, 10);  // R5 count restarted
      step(1'b0, 3'b110, 1);   // R4 short dropout mid-count
      step(1'b0, 3'b111, 30);  // R5 full recount
      step(1'b1, 3'b111, 1);   // R3 power-on pulse while locked
      step(1'b0, 3'b111, 25);  // R5 release again
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #2000000;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule